// File: doc/BRIEF.md
# Dual-Channel Integration Conversion Sequencer

This block runs integrating conversions over two pulse-rate input channels. Each channel is a digital pulse stream that stands in for a charge-balance comparator. A command byte selects which channel or channels are counted and how a conversion is timed. The block then fills two result registers: a 16-bit conversion result, and a 16-bit count of the clock cycles the last conversion covered. A one-cycle valid pulse marks each update.

Commands arrive with a strobe `cmd_we_i`. A second strobe, `rpt_i`, re-issues the stored command without new data, which is what an address-only bus write produces. There are two timing classes. An internally timed conversion counts a fixed number of cycles per stage and then starts again by itself. An externally timed conversion lasts until the next command, so the host controls the integration window. The result registers change only when a conversion completes.

Timing convention: a strobe is sampled at clock edge E0. Pulse inputs are sampled at each following edge E1..En, and the edge that closes the conversion is one of them. The outputs show the new values in the cycle after En.

Top module: `dis_conv_seq`

## Requirements
- R1: The command is decoded from bits [3:2] (timing class: 00 internal, 01 external) and bits [1:0] (channel mode: 00 channel 1, 01 channel 2, 10 difference). Bits [7:4] are ignored. Timing code 10 or 11, or mode code 11, puts the block in an idle state that produces no valid pulse and leaves the results unchanged.
- R2: In channel-1 mode the result is the number of sampled edges at which `pulse_a_i` was high, as unsigned. `pulse_b_i` has no effect.
- R3: In channel-2 mode the result is the number of sampled edges at which `pulse_b_i` was high, as unsigned. `pulse_a_i` has no effect.
- R4: Difference mode runs in two stages. The first stage counts `pulse_b_i` and the second counts `pulse_a_i`. The result is (second count − first count) in two's complement, and the period covers both stages.
- R5: An internally timed conversion lasts T_INT sampled edges per stage (2·T_INT in difference mode). It then publishes with `period_o` equal to that length and immediately starts the next conversion with the same configuration.
- R6: While an externally timed conversion runs, each strobe closes it, publishes, and starts a conversion from the new command. The period equals the number of edges from the opening strobe to the closing strobe. The exception is the first stage of difference mode, where a strobe only moves the conversion to its second stage.
- R7: `period_o` saturates at 0xFFFF instead of wrapping.
- R8: An unsigned result saturates at 0xFFFF instead of wrapping.
- R9: The difference result saturates at 0x7FFF (+32767) and 0x8000 (−32768).
- R10: The stored command persists until the next `cmd_we_i`. A pulse on `rpt_i` acts like a strobe carrying the stored command.
- R11: `result_o` and `period_o` change only together with `valid_o`. A strobe during an internally timed conversion abandons it without publishing, and the previous values stay readable.
- R12: After reset, `result_o`, `period_o` and `valid_o` are zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 8 | Command byte, taken when `cmd_we_i` is high |
| cmd_we_i | input | 1 | Strobe: a new command was received |
| rpt_i | input | 1 | Strobe: re-issue the stored command |
| pulse_a_i | input | 1 | Channel 1 pulse stream |
| pulse_b_i | input | 1 | Channel 2 pulse stream |
| result_o | output | 16 | Latest conversion result |
| period_o | output | 16 | Cycles counted in the latest conversion |
| valid_o | output | 1 | One-cycle pulse when the results update |

## Verification
The embedded properties watch on every cycle that the results move only with the valid pulse, that the stored command holds between writes, that an idle block publishes nothing, that a saturated counter stays pinned, and that an internally timed period matches the stage length. The bench alone can show that the counted values are correct: channel selection, the sign and clamping of the difference, the closing of a window by a command or a repeat strobe, and the self-restart of internal timing. Each of these depends on the pulse patterns driven over a whole window.

// File: rtl/dis_pkg.sv
package dis_pkg;

    typedef enum logic [1:0] {
        MODE_CH1  = 2'b00,
        MODE_CH2  = 2'b01,
        MODE_DIFF = 2'b10,
        MODE_NONE = 2'b11
    } chan_mode_e;

    localparam logic [1:0] TIM_INT = 2'b00;
    localparam logic [1:0] TIM_EXT = 2'b01;

    typedef struct packed {
        logic       ok;
        logic       ext;
        chan_mode_e mode;
    } cmd_cfg_t;

endpackage

// File: rtl/dis_cmd_decode.sv
module dis_cmd_decode
    import dis_pkg::*;
(
    input  logic [3:0] code_i,
    output cmd_cfg_t   cfg_o
);

    always_comb begin
        cfg_o      = '{ok: 1'b0, ext: 1'b0, mode: MODE_NONE};
        cfg_o.ext  = (code_i[3:2] == TIM_EXT);
        cfg_o.mode = chan_mode_e'(code_i[1:0]);
        // R1: only two timing codes and three channel codes are legal
        cfg_o.ok   = ((code_i[3:2] == TIM_INT) || (code_i[3:2] == TIM_EXT))
                     && (code_i[1:0] != MODE_NONE);
    end

endmodule

// File: rtl/dis_sat_counter.sv
module dis_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        nxt_o = cnt_q;
        if (inc_i && (cnt_q != CNT_MAX)) begin
            nxt_o = cnt_q + 1'b1;
        end
        cnt_d = clr_i ? '0 : nxt_o;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign q_o = cnt_q;

    // R7 / R8: a pinned counter stays pinned until cleared
    assert_sat_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/dis_result_calc.sv
module dis_result_calc
    import dis_pkg::*;
#(
    parameter int DW = 16
) (
    input  chan_mode_e    mode_i,
    input  logic [DW-1:0] cnt1_i,
    input  logic [DW-1:0] cnt2_i,
    output logic [DW-1:0] result_o
);

    localparam logic signed [DW:0] S_MAX = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [DW:0] S_MIN = {2'b11, {(DW-1){1'b0}}};

    logic signed [DW:0] diff;

    always_comb begin
        diff = $signed({1'b0, cnt1_i}) - $signed({1'b0, cnt2_i});
        unique case (mode_i)
            MODE_CH1: result_o = cnt1_i;
            MODE_CH2: result_o = cnt2_i;
            MODE_DIFF: begin
                // R9: clamp the signed difference to the output range
                if (diff > S_MAX) begin
                    result_o = {1'b0, {(DW-1){1'b1}}};
                end else if (diff < S_MIN) begin
                    result_o = {1'b1, {(DW-1){1'b0}}};
                end else begin
                    result_o = diff[DW-1:0];
                end
            end
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/dis_conv_seq.sv
module dis_conv_seq
    import dis_pkg::*;
#(
    parameter int DW    = 16,
    parameter int T_INT = 100
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [7:0]    cmd_i,
    input  logic          cmd_we_i,
    input  logic          rpt_i,
    input  logic          pulse_a_i,
    input  logic          pulse_b_i,
    output logic [DW-1:0] result_o,
    output logic [DW-1:0] period_o,
    output logic          valid_o
);

    localparam int NCH = 2;
    localparam int TW  = $clog2(T_INT + 1);
    localparam logic [TW-1:0] STAGE_LEN  = TW'(T_INT);
    localparam logic [DW-1:0] INT_PER_1  = DW'(T_INT);
    localparam logic [DW-1:0] INT_PER_2  = DW'(2 * T_INT);

    typedef struct packed {
        logic [7:0]    cmd;
        logic          run;
        logic          ext;
        chan_mode_e    mode;
        logic          stage2;
        logic [DW-1:0] result;
        logic [DW-1:0] period;
        logic          valid;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic          go, publish, start, adv, stage_done, first_diff;
    logic [7:0]    new_cmd;
    cmd_cfg_t      new_cfg, start_cfg, run_cfg;
    logic [NCH-1:0] pulse_in, cnt_en;
    logic [DW-1:0] cnt_q   [NCH];
    logic [DW-1:0] cnt_nxt [NCH];
    logic [DW-1:0] per_q, per_nxt, calc_res;
    logic [TW-1:0] tmr_q, tmr_nxt;
    logic          clr_cnt, clr_tmr;

    assign pulse_in = {pulse_b_i, pulse_a_i};
    assign go       = cmd_we_i | rpt_i;
    assign new_cmd  = cmd_we_i ? cmd_i : st_q.cmd;

    dis_cmd_decode u_decode (
        .code_i (new_cmd[3:0]),
        .cfg_o  (new_cfg)
    );

    // Channel enables: index 0 is channel 1, index 1 is channel 2
    always_comb begin
        cnt_en[0] = st_q.run && ((st_q.mode == MODE_CH1) ||
                                 (st_q.mode == MODE_DIFF && st_q.stage2));
        cnt_en[1] = st_q.run && ((st_q.mode == MODE_CH2) ||
                                 (st_q.mode == MODE_DIFF && !st_q.stage2));
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dis_sat_counter #(.W(DW)) u_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (clr_cnt),
            .inc_i  (cnt_en[ch] & pulse_in[ch]),
            .q_o    (cnt_q[ch]),
            .nxt_o  (cnt_nxt[ch])
        );
    end

    dis_sat_counter #(.W(DW)) u_period (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_cnt),
        .inc_i  (st_q.run),
        .q_o    (per_q),
        .nxt_o  (per_nxt)
    );

    dis_sat_counter #(.W(TW)) u_stage_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_tmr),
        .inc_i  (st_q.run & ~st_q.ext),
        .q_o    (tmr_q),
        .nxt_o  (tmr_nxt)
    );

    dis_result_calc #(.DW(DW)) u_calc (
        .mode_i   (st_q.mode),
        .cnt1_i   (cnt_nxt[0]),
        .cnt2_i   (cnt_nxt[1]),
        .result_o (calc_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        publish    = 1'b0;
        start      = 1'b0;
        adv        = 1'b0;
        run_cfg    = '{ok: 1'b1, ext: st_q.ext, mode: st_q.mode};
        start_cfg  = new_cfg;
        first_diff = (st_q.mode == MODE_DIFF) && !st_q.stage2;
        stage_done = st_q.run && !st_q.ext && (tmr_nxt == STAGE_LEN);

        if (go) begin
            st_d.cmd = new_cmd;
            if (st_q.run && st_q.ext && first_diff) begin
                adv = 1'b1;
            end else begin
                start   = 1'b1;
                publish = st_q.run && st_q.ext;
            end
        end else if (stage_done) begin
            if (first_diff) begin
                adv = 1'b1;
            end else begin
                publish   = 1'b1;
                start     = 1'b1;
                start_cfg = run_cfg;
            end
        end

        if (adv) begin
            st_d.stage2 = 1'b1;
        end
        if (start) begin
            st_d.run    = start_cfg.ok;
            st_d.ext    = start_cfg.ext;
            st_d.mode   = start_cfg.ok ? start_cfg.mode : MODE_NONE;
            st_d.stage2 = 1'b0;
        end
        if (publish) begin
            st_d.result = calc_res;
            st_d.period = per_nxt;
            st_d.valid  = 1'b1;
        end

        clr_cnt = start || !st_q.run;
        clr_tmr = clr_cnt || adv;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{cmd: 8'hFF, run: 1'b0, ext: 1'b0, mode: MODE_NONE,
                      stage2: 1'b0, result: '0, period: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign period_o = st_q.period;
    assign valid_o  = st_q.valid;

    assert_cmd_persist_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_we_i |=> $stable(st_q.cmd));

    assert_hold_results_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(result_o) && $stable(period_o)));

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.run && !go) |=> !valid_o);

    assert_int_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (publish && !st_q.ext) |->
            (per_nxt == ((st_q.mode == MODE_DIFF) ? INT_PER_2 : INT_PER_1)));

    assert_stage_diff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.stage2 |-> (st_q.run && st_q.mode == MODE_DIFF));

    assert_timer_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && !st_q.ext) |-> (tmr_q < STAGE_LEN));

    // The held counts never move while the block is idle
    assert_idle_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.run && !go) |=> (cnt_q[0] == '0 && cnt_q[1] == '0));

endmodule

// File: tb/dis_conv_seq_tb.sv
module dis_conv_seq_tb_top;

    localparam int T = 20;

    typedef struct packed {
        logic [7:0] cmd;
        int         l1;
        int         l2;
        int         da;
        int         db;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h04, 30, 0, 3, 1},
        '{8'h05, 25, 0, 1, 5},
        '{8'h06, 12, 18, 2, 3},
        '{8'h06, 30, 10, 1, 1},
        '{8'h00, T, 0, 2, 1},
        '{8'h01, T, 0, 1, 4},
        '{8'h02, T, T, 1, 2},
        '{8'hF4, 7, 0, 1, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd = 8'h00;
    logic        cmd_we = 1'b0;
    logic        rpt = 1'b0;
    logic        pa = 1'b0;
    logic        pb = 1'b0;
    logic [15:0] result;
    logic [15:0] period;
    logic        valid;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dis_conv_seq #(.DW(16), .T_INT(T)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cmd_i     (cmd),
        .cmd_we_i  (cmd_we),
        .rpt_i     (rpt),
        .pulse_a_i (pa),
        .pulse_b_i (pb),
        .result_o  (result),
        .period_o  (period),
        .valid_o   (valid)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        cmd = c;
        cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    function automatic logic [15:0] usat(input int v);
        return (v > 65535) ? 16'hFFFF : v[15:0];
    endfunction

    task automatic run_case(input logic [7:0] c, input int l1, input int l2,
                            input int da, input int db);
        bit ext = (c[3:2] == 2'b01);
        int md = int'(c[1:0]);
        int total = (md == 2) ? l1 + l2 : l1;
        int sa = 0;
        int sb = 0;
        int df;
        logic [15:0] exp;
        string rt, tt;
        rt = (md == 0) ? "R2" : (md == 1) ? "R3" : "R4";
        tt = ext ? "R6" : "R5";
        @(negedge clk);
        cmd = c; cmd_we = 1'b1; pa = 1'b0; pb = 1'b0;
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            pa = (da != 0) && (i % da == 0);
            pb = (db != 0) && (i % db == 0);
            cmd_we = ext && (((md == 2) && (i == l1)) || (i == total));
            if (md == 0 && pa) sa++;
            if (md == 1 && pb) sb++;
            if (md == 2 && i <= l1 && pb) sb++;
            if (md == 2 && i > l1 && pa) sa++;
        end
        @(negedge clk);
        cmd_we = 1'b0; pa = 1'b0; pb = 1'b0;
        if (md == 0) exp = usat(sa);
        else if (md == 1) exp = usat(sb);
        else begin
            df = sa - sb;
            if (df > 32767) df = 32767;
            if (df < -32768) df = -32768;
            exp = df[15:0];
        end
        check({tt, " valid at close"}, 32'(valid), 32'd1);
        check({rt, "/R8/R9 result"}, 32'(result), 32'(exp));
        check({tt, "/R7 period"}, 32'(period), 32'(usat(total)));
        @(negedge clk);
        check({tt, " valid one cycle"}, 32'(valid), 32'd0);
        send(8'hFF);
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int nv;
        logic [15:0] prev;

        // R12: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 result", 32'(result), 32'd0);
        check("R12 period", 32'(period), 32'd0);
        check("R12 valid", 32'(valid), 32'd0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            run_case(VECS[v].cmd, VECS[v].l1, VECS[v].l2, VECS[v].da, VECS[v].db);
        end

        // R5: internal timing restarts by itself
        pa = 1'b1; pb = 1'b0;
        @(negedge clk);
        cmd = 8'h00; cmd_we = 1'b1;
        nv = 0;
        for (int k = 1; k <= 65; k++) begin
            @(negedge clk);
            cmd_we = 1'b0;
            if (valid) nv++;
        end
        check("R5 auto-restart count", 32'(nv), 32'd3);
        check("R5 restart result", 32'(result), 32'd20);
        check("R5 restart period", 32'(period), 32'd20);
        send(8'hFF);

        // R11: strobe during an internal conversion abandons it
        pa = 1'b1; pb = 1'b0;
        @(negedge clk);
        cmd = 8'h00; cmd_we = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            cmd_we = 1'b0;
        end
        cmd = 8'h01; cmd_we = 1'b1;
        nv = 0;
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            cmd_we = 1'b0;
            if (k == 15) check("R11 old result readable", 32'(result), 32'd20);
            if (valid && nv == 0) nv = k;
        end
        check("R11 restart publish cycle", 32'(nv), 32'd21);
        check("R11/R3 new result", 32'(result), 32'd0);
        send(8'hFF);
        pa = 1'b0;

        // R10: repeat strobe reuses the stored command
        pa = 1'b1;
        @(negedge clk);
        cmd = 8'h04; cmd_we = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            cmd_we = 1'b0;
            cmd = 8'h00;
            rpt = (k == 9);
        end
        @(negedge clk);
        rpt = 1'b0;
        check("R10 repeat closes valid", 32'(valid), 32'd1);
        check("R10 repeat period", 32'(period), 32'd9);
        check("R10 repeat result", 32'(result), 32'd9);
        for (int k = 11; k <= 15; k++) begin
            @(negedge clk);
            rpt = (k == 15);
        end
        @(negedge clk);
        rpt = 1'b0;
        check("R10 second repeat period", 32'(period), 32'd6);
        check("R10 second repeat result", 32'(result), 32'd6);
        send(8'hFF);
        @(negedge clk);

        // R1: illegal codes idle the block
        prev = result;
        pa = 1'b1; pb = 1'b1;
        nv = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            cmd = (c == 0) ? 8'h03 : (c == 1) ? 8'h08 : 8'h0C;
            cmd_we = 1'b1;
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                cmd_we = 1'b0;
                if (valid) nv++;
            end
        end
        check("R1 idle no valid", 32'(nv), 32'd0);
        check("R1 idle result unchanged", 32'(result), 32'(prev));
        pa = 1'b0; pb = 1'b0;

        // R7 / R8: unsigned and period saturation
        run_case(8'h04, 66000, 0, 1, 0);
        // R9: signed clamp, both directions
        run_case(8'h06, 32800, 1, 0, 1);
        run_case(8'h06, 1, 32800, 1, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule